// File: doc/BRIEF.md
# Floppy Track DMA Controller

This block moves one track of raw MFM bit-cell data between the serial data path of a disk drive and system memory, one 16-bit word per DMA transaction. On the read side, a data separator supplies bits with a strobe. The controller keeps a sliding 16-bit window over the incoming bits and compares it with a programmable sync pattern. It assembles bytes for a live status readback and, while a transfer runs, packs words that it writes to memory at an incrementing even address. On the write side, it fetches words from memory before they are needed and shifts each word out most significant bit first, one bit per cell period.

Software programs four word registers: the memory pointer, the length/control word, the sync pattern and the adjust word. A transfer begins only when the same length/control value, with its enable bit set, is written twice in a row. A write with the enable bit clear stops any transfer at once. The block raises two interrupts. One fires whenever the sync pattern is seen. The other fires when a transfer has moved all of its words.

Top module: `fdc_track_dma`

## Requirements
- R1: After reset, the status word reads 16'h0000, and `dma_req`, `wr_stb`, `irq_sync` and `irq_done` are all low.
- R2: Register select 1 is length/control: bit 15 enables, bit 14 selects disk write (1) or disk read (0), and bits 13:0 give the word count. A transfer starts only when a length/control write with bit 15 set carries the same value as the previous length/control write. A single write, or a write that differs from the one before it, leaves the block idle. Once a transfer has started, two further matching writes are needed to start the next one.
- R3: A length/control write with bit 15 clear stops the transfer on the next cycle. It drops any pending request, clears the remaining count and does not raise `irq_done`. Later disk bits cause no memory writes.
- R4: Register select 0 loads the pointer with bit 0 forced to 0. Each completed word transaction (`dma_req` and `dma_ack` both high) advances the pointer by 2 and lowers the remaining count by 1. Transactions use addresses pointer, pointer+2, and so on.
- R5: Every strobed input bit shifts into a 16-bit window. `irq_sync` pulses for one cycle, one cycle after the strobe whose bit makes the window equal to the sync register. It does so whether or not a transfer is running and whatever the adjust setting.
- R6: When bit 10 of the adjust register (select 3) is set, a disk read ignores the bits before the first sync match. The first word stored is the 16 bits that follow the match.
- R7: When adjust bit 10 is clear, a disk read packs words from the first 16 bits strobed after the start, with no alignment. Each packed word is written to memory with its first bit in bit 15.
- R8: `irq_done` pulses once, and status bit 14 clears, when the count reaches zero. For a disk read this is the cycle after the last memory write completes. For a disk write it is the cycle after the last bit strobe.
- R9: A disk write fetches words (`dma_we` low) and emits them most significant bit first on `wr_bit`, with `wr_stb` pulsing once every CELL_DIV cycles. Successive words follow with no gap.
- R10: In the status word, bit 15 is byte-ready, bit 14 is transfer active, bit 13 mirrors bit 14 of the last length/control write, and bits 7:0 hold the last assembled byte. A byte completes every 8 strobed bits and also on each sync match, which realigns the byte count. A `stat_rd` pulse clears byte-ready unless a byte completes in the same cycle.
- R11: Status bit 12 rises on a sync match and stays set for SYNC_HOLD cycles afterwards.
- R12: The sync register (select 2) resets to 16'h4489 and can be rewritten to any pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pointer, 1 length/control, 2 sync, 3 adjust |
| reg_wdata | input | 16 | Register write data |
| stat_rd | input | 1 | Status read strobe; clears byte-ready |
| stat_data | output | 16 | Live status word |
| dma_req | output | 1 | Word transaction request, held until acknowledged |
| dma_we | output | 1 | 1: store word to memory, 0: fetch word from memory |
| dma_addr | output | ADDR_W | Word address (even) |
| dma_wdata | output | 16 | Word to store |
| dma_rdata | input | 16 | Fetched word, valid with dma_ack |
| dma_ack | input | 1 | Transaction acknowledge |
| rd_bit_vld | input | 1 | Strobe for one disk bit cell |
| rd_bit | input | 1 | Disk bit value |
| wr_bit | output | 1 | Disk write bit, valid with wr_stb |
| wr_stb | output | 1 | One pulse per written bit cell |
| irq_sync | output | 1 | Sync pattern seen (one-cycle pulse) |
| irq_done | output | 1 | Transfer complete (one-cycle pulse) |

## Verification
The bench builds the block with CELL_DIV = 4 and SYNC_HOLD = 6, leaving the address and count widths at their defaults. The short cell period lets a three-word disk write, with its back-to-back word reloads and strobe spacing, finish in a couple of hundred cycles. The short hold window lets the bench watch status bit 12 both rise and fall within a few cycles of a sync match. With these values, the alignment hunt, the stop in the middle of a transfer and the arming sequences all fit in one short run.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam logic [1:0] SEL_PTR  = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_SYNC = 2'd2;
  localparam logic [1:0] SEL_ADJ  = 2'd3;

  localparam int LEN_GO   = 15;
  localparam int LEN_DIR  = 14;
  localparam int ADJ_SYNC = 10;

  localparam logic [15:0] SYNC_RESET = 16'h4489;

  typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_COLLECT} rx_state_e;

  // Arming rule: enable set and identical to the previous control write
  function automatic logic arm_match(logic prev_ok, logic [15:0] prev, logic [15:0] now);
    return prev_ok && now[LEN_GO] && (prev == now);
  endfunction

  function automatic logic [15:0] pack_status(logic rdy, logic act, logic dir,
                                              logic held, logic [7:0] b);
    return {rdy, act, dir, held, 4'b0000, b};
  endfunction
endpackage

// File: rtl/fdc_arm.sv
module fdc_arm #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_len,
  input  logic [15:0]      wdata,
  input  logic             active,
  output logic             start_evt,
  output logic             stop_evt,
  output logic             start_write,
  output logic [CNT_W-1:0] start_count,
  output logic             dir_bit
);
  import fdc_pkg::*;

  logic [15:0] prev_q;
  logic        prev_ok_q;

  assign start_evt   = wr_len && !active && arm_match(prev_ok_q, prev_q, wdata);
  assign stop_evt    = wr_len && !wdata[LEN_GO];
  assign start_write = wdata[LEN_DIR];
  assign start_count = wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
      dir_bit   <= 1'b0;
    end else if (wr_len) begin
      prev_q    <= wdata;
      prev_ok_q <= !start_evt;
      dir_bit   <= wdata[LEN_DIR];
    end
  end
endmodule

// File: rtl/fdc_rx.sv
module fdc_rx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_vld,
  input  logic        bit_in,
  input  logic [15:0] sync_word,
  input  logic        arm,
  input  logic        need_sync,
  input  logic        en,
  output logic        sync_evt,
  output logic        byte_evt,
  output logic [7:0]  byte_q,
  output logic        word_evt,
  output logic [15:0] word_q
);
  import fdc_pkg::*;

  rx_state_e   st_q;
  logic [15:0] win_q;
  logic [15:0] wsh_q;
  logic [7:0]  bsh_q;
  logic [2:0]  bcnt_q;
  logic [3:0]  wcnt_q;
  logic [15:0] window;

  assign window   = {win_q[14:0], bit_in};
  assign sync_evt = bit_vld && (window == sync_word);
  assign byte_evt = bit_vld && (sync_evt || bcnt_q == 3'd7);
  assign word_evt = bit_vld && (st_q == RX_COLLECT) && (wcnt_q == 4'd15);
  assign word_q   = {wsh_q[14:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      bsh_q  <= '0;
      bcnt_q <= '0;
      byte_q <= '0;
    end else if (bit_vld) begin
      win_q  <= window;
      bsh_q  <= {bsh_q[6:0], bit_in};
      bcnt_q <= sync_evt ? 3'd0 : bcnt_q + 3'd1;
      if (byte_evt) byte_q <= {bsh_q[6:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      wsh_q  <= '0;
      wcnt_q <= '0;
    end else if (arm) begin
      st_q   <= need_sync ? RX_HUNT : RX_COLLECT;
      wcnt_q <= '0;
    end else if (!en) begin
      st_q <= RX_IDLE;
    end else if (bit_vld) begin
      case (st_q)
        RX_HUNT: if (sync_evt) begin
          st_q   <= RX_COLLECT;
          wcnt_q <= '0;
        end
        RX_COLLECT: begin
          wsh_q  <= word_q;
          wcnt_q <= wcnt_q + 4'd1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fdc_tx.sv
module fdc_tx #(
  parameter int CELL_DIV = 56
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        load,
  input  logic [15:0] load_data,
  output logic        buf_full,
  output logic        busy,
  output logic        wr_bit,
  output logic        wr_stb
);
  localparam int TW = (CELL_DIV > 2) ? $clog2(CELL_DIV) : 1;
  localparam logic [TW-1:0] TMR_LAST = TW'(CELL_DIV - 1);

  logic [15:0]   buf_q;
  logic [15:0]   sh_q;
  logic [4:0]    bits_q;
  logic [TW-1:0] tmr_q;
  logic          tick;

  assign busy = (bits_q != 5'd0);
  assign tick = busy && (tmr_q == TMR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
      sh_q     <= '0;
      bits_q   <= '0;
      tmr_q    <= '0;
      wr_bit   <= 1'b0;
      wr_stb   <= 1'b0;
    end else if (flush) begin
      buf_full <= 1'b0;
      bits_q   <= '0;
      tmr_q    <= '0;
      wr_stb   <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (busy) tmr_q <= tick ? '0 : tmr_q + TW'(1);
      if (tick) begin
        wr_bit <= sh_q[15];
        wr_stb <= 1'b1;
        if (bits_q == 5'd1 && buf_full) begin
          sh_q     <= buf_q;
          bits_q   <= 5'd16;
          buf_full <= 1'b0;
        end else begin
          sh_q   <= {sh_q[14:0], 1'b0};
          bits_q <= bits_q - 5'd1;
        end
      end else if (!busy && buf_full) begin
        sh_q     <= buf_q;
        bits_q   <= 5'd16;
        buf_full <= 1'b0;
        tmr_q    <= '0;
      end
      if (load) begin
        buf_q    <= load_data;
        buf_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fdc_track_dma.sv
module fdc_track_dma #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 14,
  parameter int CELL_DIV  = 56,
  parameter int SYNC_HOLD = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [15:0]       reg_wdata,
  input  logic              stat_rd,
  output logic [15:0]       stat_data,
  output logic              dma_req,
  output logic              dma_we,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [15:0]       dma_wdata,
  input  logic [15:0]       dma_rdata,
  input  logic              dma_ack,
  input  logic              rd_bit_vld,
  input  logic              rd_bit,
  output logic              wr_bit,
  output logic              wr_stb,
  output logic              irq_sync,
  output logic              irq_done
);
  import fdc_pkg::*;

  localparam int HW = $clog2(SYNC_HOLD + 1);

  function automatic logic [ADDR_W-1:0] ptr_align(logic [15:0] w);
    logic [ADDR_W-1:0] t;
    t    = ADDR_W'(w);
    t[0] = 1'b0;
    return t;
  endfunction

  function automatic logic [ADDR_W-1:0] ptr_step(logic [ADDR_W-1:0] p);
    return p + ADDR_W'(2);
  endfunction

  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              active, is_wr;
  logic [15:0]       sync_q;
  logic              adj_sync_q;
  logic              byte_ready_q;
  logic [HW-1:0]     hold_q;

  // named internal events
  logic              start_evt, stop_evt, start_write, dir_bit;
  logic [CNT_W-1:0]  start_count;
  logic              sync_evt, byte_evt, word_evt;
  logic [7:0]        byte_q;
  logic [15:0]       word_q;
  logic              tx_full, tx_busy;
  logic              xfer, finish_evt, fetch_evt;

  assign xfer       = dma_req && dma_ack;
  assign finish_evt = active && (cnt_q == '0) && !dma_req && (!is_wr || (!tx_full && !tx_busy));
  assign fetch_evt  = active && is_wr && (cnt_q != '0) && !dma_req && !tx_full;

  fdc_arm #(.CNT_W(CNT_W)) u_arm (
    .clk(clk), .rst_n(rst_n),
    .wr_len(reg_wr && reg_sel == SEL_LEN), .wdata(reg_wdata), .active(active),
    .start_evt(start_evt), .stop_evt(stop_evt), .start_write(start_write),
    .start_count(start_count), .dir_bit(dir_bit)
  );

  fdc_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .bit_vld(rd_bit_vld), .bit_in(rd_bit), .sync_word(sync_q),
    .arm(start_evt && !start_write), .need_sync(adj_sync_q), .en(active && !is_wr),
    .sync_evt(sync_evt), .byte_evt(byte_evt), .byte_q(byte_q),
    .word_evt(word_evt), .word_q(word_q)
  );

  fdc_tx #(.CELL_DIV(CELL_DIV)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .flush(stop_evt), .load(xfer && !dma_we), .load_data(dma_rdata),
    .buf_full(tx_full), .busy(tx_busy), .wr_bit(wr_bit), .wr_stb(wr_stb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q        <= '0;
      cnt_q        <= '0;
      active       <= 1'b0;
      is_wr        <= 1'b0;
      sync_q       <= SYNC_RESET;
      adj_sync_q   <= 1'b0;
      byte_ready_q <= 1'b0;
      hold_q       <= '0;
      dma_req      <= 1'b0;
      dma_we       <= 1'b0;
      dma_wdata    <= '0;
      irq_sync     <= 1'b0;
      irq_done     <= 1'b0;
    end else begin
      irq_sync <= sync_evt;
      irq_done <= finish_evt && !stop_evt;

      if (xfer) begin
        dma_req <= 1'b0;
        ptr_q   <= ptr_step(ptr_q);
        cnt_q   <= cnt_q - CNT_W'(1);
      end else if (word_evt && active && !is_wr && cnt_q != '0) begin
        dma_req   <= 1'b1;
        dma_we    <= 1'b1;
        dma_wdata <= word_q;
      end else if (fetch_evt) begin
        dma_req <= 1'b1;
        dma_we  <= 1'b0;
      end

      if (reg_wr) begin
        case (reg_sel)
          SEL_PTR:  ptr_q      <= ptr_align(reg_wdata);
          SEL_SYNC: sync_q     <= reg_wdata;
          SEL_ADJ:  adj_sync_q <= reg_wdata[ADJ_SYNC];
          default: ;
        endcase
      end

      if (finish_evt) active <= 1'b0;
      if (start_evt) begin
        active <= 1'b1;
        is_wr  <= start_write;
        cnt_q  <= start_count;
      end
      if (stop_evt) begin
        active  <= 1'b0;
        dma_req <= 1'b0;
        cnt_q   <= '0;
      end

      if (byte_evt)     byte_ready_q <= 1'b1;
      else if (stat_rd) byte_ready_q <= 1'b0;

      if (sync_evt)            hold_q <= HW'(SYNC_HOLD);
      else if (hold_q != '0)   hold_q <= hold_q - HW'(1);
    end
  end

  assign dma_addr  = ptr_q;
  assign stat_data = pack_status(byte_ready_q, active, dir_bit, hold_q != '0, byte_q);
endmodule

// File: rtl/fdc_track_dma_chk.sv
module fdc_track_dma_chk #(
  parameter int ADDR_W   = 16,
  parameter int CELL_DIV = 56
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [15:0]       reg_wdata,
  input logic              stat_rd,
  input logic [15:0]       stat_data,
  input logic              dma_req,
  input logic [ADDR_W-1:0] dma_addr,
  input logic              wr_stb,
  input logic              irq_sync,
  input logic              irq_done,
  input logic              rd_bit_vld,
  input logic              sync_evt,
  input logic              byte_evt,
  input logic              active
);
  assert_start_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(reg_wr && reg_sel == 2'd1 && reg_wdata[15]));

  assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && !reg_wdata[15]) |=> (!dma_req && !stat_data[14]));

  assert_addr_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !dma_addr[0]);

  assert_sync_after_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sync |-> $past(rd_bit_vld));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> !stat_data[14]);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  generate
    if (CELL_DIV > 1) begin : g_gap
      assert_cell_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
    end
  endgenerate

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !byte_evt) |=> !stat_data[15]);

  assert_hold_from_sync_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_data[12]) |-> $past(sync_evt));
endmodule

bind fdc_track_dma fdc_track_dma_chk #(.ADDR_W(ADDR_W), .CELL_DIV(CELL_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .stat_rd(stat_rd), .stat_data(stat_data), .dma_req(dma_req), .dma_addr(dma_addr),
  .wr_stb(wr_stb), .irq_sync(irq_sync), .irq_done(irq_done), .rd_bit_vld(rd_bit_vld),
  .sync_evt(sync_evt), .byte_evt(byte_evt), .active(active)
);

// File: tb/tb_fdc_track_dma.sv
module tb_fdc_track_dma;
  localparam int CELL = 4;
  localparam int HOLD = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        stat_rd = 1'b0;
  logic [15:0] stat_data;
  logic        dma_req, dma_we;
  logic [15:0] dma_addr, dma_wdata;
  logic [15:0] dma_rdata = '0;
  logic        dma_ack = 1'b0;
  logic        rd_bit_vld = 1'b0;
  logic        rd_bit = 1'b0;
  logic        wr_bit, wr_stb, irq_sync, irq_done;

  always #10 clk = ~clk;

  fdc_track_dma #(.ADDR_W(16), .CNT_W(14), .CELL_DIV(CELL), .SYNC_HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .stat_rd(stat_rd), .stat_data(stat_data), .dma_req(dma_req), .dma_we(dma_we),
    .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_ack(dma_ack),
    .rd_bit_vld(rd_bit_vld), .rd_bit(rd_bit), .wr_bit(wr_bit), .wr_stb(wr_stb),
    .irq_sync(irq_sync), .irq_done(irq_done)
  );

  int checks = 0, fails = 0;
  int n_sync = 0, n_done = 0, n_stb = 0;
  int cyc = 0, last_stb = -1;
  bit finished = 0;
  string rd_tag = "R7";
  logic [15:0] rd_exp_addr[$];
  logic [15:0] rd_exp_data[$];
  logic [15:0] src_q[$];
  logic        bit_q[$];
  logic [15:0] exp_wr_addr = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rd_bit_vld = 1'b1; rd_bit = b;
    @(negedge clk);
    rd_bit_vld = 1'b0;
    wait_n(2);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic expect_store(input logic [15:0] a, input logic [15:0] d);
    rd_exp_addr.push_back(a);
    rd_exp_data.push_back(d);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) cyc++;

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    if (dma_ack) begin
      dma_ack = 1'b0;
    end else if (dma_req) begin
      if (dma_we) begin
        if (rd_exp_addr.size() == 0) begin
          check(1'b0, rd_tag, {dma_addr, dma_wdata}, 32'h0);
        end else begin
          logic [15:0] ea, ed;
          ea = rd_exp_addr.pop_front();
          ed = rd_exp_data.pop_front();
          check_eq("R4", dma_addr, ea);
          check_eq(rd_tag, dma_wdata, ed);
        end
      end else begin
        logic [15:0] w;
        check_eq("R4", dma_addr, exp_wr_addr);
        exp_wr_addr = exp_wr_addr + 16'd2;
        if (src_q.size() == 0) begin
          check(1'b0, "R9", 32'h1, 32'h0);
          w = '0;
        end else begin
          w = src_q.pop_front();
        end
        dma_rdata = w;
        for (int i = 15; i >= 0; i--) bit_q.push_back(w[i]);
      end
      dma_ack = 1'b1;
    end
    if (wr_stb) begin
      n_stb++;
      if (bit_q.size() == 0) check(1'b0, "R9", {31'b0, wr_bit}, 32'hx);
      else check_eq("R9", {31'b0, wr_bit}, {31'b0, bit_q.pop_front()});
      if (last_stb >= 0) check_eq("R9", cyc - last_stb, CELL);
      last_stb = cyc;
    end
    if (irq_sync) n_sync++;
    if (irq_done) n_done++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int d0, s0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    check_eq("R1", stat_data, 16'h0000);
    check_eq("R1", {dma_req, wr_stb, irq_sync, irq_done}, 4'b0000);

    // R12 default sync, R5 pulse, R10 byte/status, R11 hold
    send_word(16'h4489);
    check_eq("R5", n_sync, 1);
    check_eq("R10", stat_data, 16'h9089);
    wait_n(HOLD);
    check_eq("R11", stat_data[12], 1'b0);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    check_eq("R10", stat_data, 16'h0089);

    // R2 arming, R7 unaligned read, R4 pointer
    wr_reg(2'd0, 16'h1001);
    wr_reg(2'd1, 16'h8002);
    wait_n(4);
    check_eq("R2", {stat_data[14], dma_req}, 2'b00);
    wr_reg(2'd1, 16'h8003);
    wait_n(4);
    check_eq("R2", stat_data[14], 1'b0);
    wr_reg(2'd1, 16'h8003);
    wait_n(1);
    check_eq("R2", stat_data[14], 1'b1);
    rd_tag = "R7";
    expect_store(16'h1000, 16'hA5C3);
    expect_store(16'h1002, 16'h1234);
    expect_store(16'h1004, 16'h0F01);
    d0 = n_done;
    send_word(16'hA5C3);
    send_word(16'h1234);
    send_word(16'h0F01);
    wait_n(4);
    check_eq("R7", rd_exp_addr.size(), 0);
    check_eq("R8", n_done, d0 + 1);
    check_eq("R8", stat_data[14], 1'b0);

    // R6 aligned read with a programmed pattern (R12)
    wr_reg(2'd3, 16'h0400);
    wr_reg(2'd2, 16'h1357);
    wr_reg(2'd0, 16'h2000);
    wr_reg(2'd1, 16'h8001);
    wr_reg(2'd1, 16'h8001);
    rd_tag = "R6";
    expect_store(16'h2000, 16'hBEEF);
    d0 = n_done;
    send_word(16'hFFFF);
    s0 = n_sync;
    send_word(16'h1357);
    check_eq("R12", n_sync, s0 + 1);
    send_word(16'hBEEF);
    wait_n(4);
    check_eq("R6", rd_exp_addr.size(), 0);
    check_eq("R8", n_done, d0 + 1);

    // R3 stop mid transfer
    wr_reg(2'd3, 16'h0000);
    wr_reg(2'd0, 16'h4000);
    wr_reg(2'd1, 16'h8005);
    wr_reg(2'd1, 16'h8005);
    rd_tag = "R3";
    expect_store(16'h4000, 16'h4242);
    send_word(16'h4242);
    d0 = n_done;
    wr_reg(2'd1, 16'h0000);
    check_eq("R3", stat_data[14], 1'b0);
    send_word(16'h7777);
    wait_n(4);
    check_eq("R3", rd_exp_addr.size(), 0);
    check_eq("R3", n_done, d0);
    check_eq("R3", dma_req, 1'b0);

    // R9 disk write, R10 direction mirror, R8 completion
    wr_reg(2'd0, 16'h3001);
    exp_wr_addr = 16'h3000;
    src_q.push_back(16'hC0A5);
    src_q.push_back(16'h0F0F);
    src_q.push_back(16'h8001);
    last_stb = -1;
    n_stb = 0;
    d0 = n_done;
    wr_reg(2'd1, 16'hC003);
    wr_reg(2'd1, 16'hC003);
    wait_n(2);
    check_eq("R10", stat_data[14:13], 2'b11);
    wait_n(260);
    check_eq("R9", n_stb, 48);
    check_eq("R9", bit_q.size(), 0);
    check_eq("R9", src_q.size(), 0);
    check_eq("R8", n_done, d0 + 1);
    check_eq("R8", stat_data[14], 1'b0);

    finished = 1;
    summary();
    $finish;
  end
endmodule